// File: doc/BRIEF.md
# Maskable Interrupt Priority Resolver

This block chooses which of a fixed set of maskable interrupt sources the CPU services next, and presents the 16-bit address of that source's vector. There are twelve vector slots. Each has a word address of the form $FFxx, and the addresses descend in steps of two from $FFE8 to $FFD2. Without further instruction, the source whose vector sits at the higher address wins.

Software can promote one source above all the others. It does so by writing the low byte of that source's vector address into a small priority register. That register accepts writes only while the CPU's I mask is set, and it can be read at any time. While the I mask is set the block also withholds every request.

Slot map, from index 0 to 11, with the vector low byte for each:

| Index | Low byte | Source |
|---|---|---|
| 0 | E8 | timer channel 3 |
| 1 | E6 | timer channel 4 |
| 2 | E4 | timer channel 5 |
| 3 | E2 | timer channel 6 |
| 4 | E0 | timer channel 7 |
| 5 | DE | timer overflow |
| 6 | DC | pulse accumulator overflow |
| 7 | DA | pulse accumulator edge |
| 8 | D8 | SPI |
| 9 | D6 | SCI0 |
| 10 | D4 | reserved |
| 11 | D2 | ATD |

The request lines arrive already gated by each source's local enables. The four SCI0 sub-conditions enter on their own lines and are merged into slot 9.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the priority register reads $F2, `irq_pending` is 0 and `irq_vector` is $0000.
- R2: Without elevation, the lowest requesting slot index, which is the highest vector address, wins.
- R3: The vector for slot index i is {$FF, $E8 − 2·i}. For example, slot 0 gives $FFE8, slot 8 gives $FFD8 and slot 11 gives $FFD2.
- R4: While `i_mask` is 1, `irq_pending` is 0 and `irq_vector` is $0000, whatever requests are active.
- R5: A register write takes effect only when `i_mask` is 1. A write made while `i_mask` is 0 leaves the read value unchanged.
- R6: The read value always has bits 7:6 = 11 and bit 0 = 0. Only bits 5:1 are stored from a write.
- R7: When the register value equals a requesting slot's vector low byte, that slot wins over every other slot.
- R8: Elevation never creates a request. An elevated slot with no request falls back to the fixed order, and with no request at all nothing is pending.
- R9: A register value that names the reserved slot ($D4), or that names no slot (for example $80 or $F2), leaves the fixed order in force.
- R10: Slot 9 (SCI0) requests when any one of its four sub-condition lines is 1.
- R11: The request line of reserved slot 10 is ignored, so vector $FFD4 is never presented.
- R12: Outputs are registered. They reflect the inputs and register state one clock edge after those inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_mask | input | 1 | CPU I mask. A 1 inhibits maskable interrupts |
| req | input | 12 | Per-slot request lines, already locally enabled, indexed by slot |
| sci_sub | input | 4 | Enabled SCI0 sub-conditions: transmit, transmit complete, receive, idle |
| reg_wr_en | input | 1 | Write strobe for the priority register |
| reg_wr_data | input | 8 | Write data for the priority register |
| reg_rd_data | output | 8 | Current priority register value |
| irq_pending | output | 1 | A maskable interrupt is to be serviced |
| irq_vector | output | 16 | Vector address of the selected source, $0000 when none |

## Verification
The assertions check on every cycle the properties that hold whatever the inputs are:
- a set I mask clears the pending output on the next edge;
- no request leads to no pending output;
- a presented vector lies in the mapped range, is even and is never the reserved slot;
- an idle output carries $0000;
- a write made while the mask is clear leaves the register untouched, and an accepted write stores its select bits.

Which slot actually wins needs the bench's scenarios. These cover fixed order among mixed requests, elevation of a requested slot, elevation of an unrequested, reserved or unmapped value, the OR of the SCI0 sub-conditions, and the fixed bits on read-back.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam int unsigned NSLOT     = 12;
    localparam int unsigned TOP_LOW   = 'hE8;
    localparam logic [7:0]  VEC_HIGH  = 8'hFF;
    localparam int unsigned SCI_SLOT  = 9;
    localparam int unsigned SCI_SUBS  = 4;
    localparam logic [NSLOT-1:0] RSVD_MASK = 12'h400;
    localparam logic [7:0]  SEL_RESET = 8'hF2;
    localparam int unsigned IDX_W     = $clog2(NSLOT);

    typedef struct packed {
        logic        pend;
        logic [15:0] vec;
    } out_t;

    function automatic logic [7:0] slot_low(input int unsigned i);
        return 8'(TOP_LOW - 2 * i);
    endfunction

endpackage

// File: rtl/ipr_prio_reg.sv
module ipr_prio_reg
    import ipr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       i_mask,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] sel_byte
);

    typedef struct packed {
        logic [4:0] sel;
    } reg_t;

    reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en && i_mask) begin
            reg_d.sel = wr_data[5:1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.sel <= SEL_RESET[5:1];
        end else begin
            reg_q <= reg_d;
        end
    end

    assign sel_byte = {2'b11, reg_q.sel, 1'b0};

    // R5: a write made while the mask is clear is dropped
    a_r5_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !i_mask) |=> $stable(reg_q.sel));

    // R5/R6: an accepted write keeps its select bits
    a_r6_stored_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && i_mask) |=> (reg_q.sel == $past(wr_data[5:1])));

endmodule

// File: rtl/ipr_req_merge.sv
module ipr_req_merge
    import ipr_pkg::*;
(
    input  logic [NSLOT-1:0]    req,
    input  logic [SCI_SUBS-1:0] sci_sub,
    output logic [NSLOT-1:0]    eff_req
);

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_slot
            if (RSVD_MASK[g]) begin : g_rsvd
                assign eff_req[g] = 1'b0;
            end else if (g == SCI_SLOT) begin : g_sci
                assign eff_req[g] = req[g] | (|sci_sub);
            end else begin : g_plain
                assign eff_req[g] = req[g];
            end
        end
    endgenerate

endmodule

// File: rtl/ipr_pick.sv
module ipr_pick
    import ipr_pkg::*;
(
    input  logic [NSLOT-1:0] eff_req,
    input  logic [7:0]       sel_byte,
    output logic             found,
    output logic [IDX_W-1:0] win_idx
);

    logic [NSLOT-1:0] elev_hit;

    genvar g;
    generate
        for (g = 0; g < NSLOT; g++) begin : g_hit
            if (RSVD_MASK[g]) begin : g_none
                assign elev_hit[g] = 1'b0;
            end else begin : g_cmp
                assign elev_hit[g] = eff_req[g] && (sel_byte == slot_low(g));
            end
        end
    endgenerate

    always_comb begin
        found   = |eff_req;
        win_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (eff_req[i]) win_idx = IDX_W'(i);
        end
        for (int i = 0; i < NSLOT; i++) begin
            if (elev_hit[i]) win_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import ipr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_mask,
    input  logic [NSLOT-1:0]    req,
    input  logic [SCI_SUBS-1:0] sci_sub,
    input  logic                reg_wr_en,
    input  logic [7:0]          reg_wr_data,
    output logic [7:0]          reg_rd_data,
    output logic                irq_pending,
    output logic [15:0]         irq_vector
);

    logic [NSLOT-1:0] eff_req;
    logic [7:0]       sel_byte;
    logic             found;
    logic [IDX_W-1:0] win_idx;
    out_t             out_d, out_q;

    ipr_prio_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_mask   (i_mask),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .sel_byte (sel_byte)
    );

    ipr_req_merge u_merge (
        .req     (req),
        .sci_sub (sci_sub),
        .eff_req (eff_req)
    );

    ipr_pick u_pick (
        .eff_req  (eff_req),
        .sel_byte (sel_byte),
        .found    (found),
        .win_idx  (win_idx)
    );

    always_comb begin
        out_d = '0;
        if (!i_mask && found) begin
            out_d.pend = 1'b1;
            out_d.vec  = {VEC_HIGH, slot_low(32'(win_idx))};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign reg_rd_data = sel_byte;
    assign irq_pending = out_q.pend;
    assign irq_vector  = out_q.vec;

    // R4: a set mask blocks the next output
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        i_mask |=> !irq_pending);

    // R4: idle output carries a zero vector
    a_r4_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> (irq_vector == 16'h0000));

    // R8: no request of any kind means nothing pending next cycle
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|req) && !(|sci_sub)) |=> !irq_pending);

    // R3: a presented vector is even and inside the mapped range
    a_r3_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (irq_vector[15:8] == VEC_HIGH && !irq_vector[0]
                         && irq_vector[7:0] <= slot_low(0)
                         && irq_vector[7:0] >= slot_low(NSLOT - 1)));

    // R11: the reserved vector never appears
    a_r11_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (irq_vector != 16'hFFD4));

endmodule

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_mask = 1'b0;
    logic [11:0] req = '0;
    logic [3:0]  sci_sub = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_data = '0;
    logic [7:0]  reg_rd_data;
    logic        irq_pending;
    logic [15:0] irq_vector;

    int errors = 0;
    int checks = 0;
    logic [7:0] cur_sel = 8'hF2;
    logic [16:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    irq_prio_resolver uut (
        .clk(clk), .rst_n(rst_n), .i_mask(i_mask), .req(req), .sci_sub(sci_sub),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .irq_pending(irq_pending), .irq_vector(irq_vector)
    );

    always #2 clk = ~clk;

    function automatic logic [16:0] model(input logic m, input logic [11:0] r,
                                          input logic [3:0] s, input logic [7:0] sel);
        logic [11:0] e;
        int k;
        if (m) return '0;
        e = r;
        e[10] = 1'b0;
        e[9] = e[9] | (|s);
        if (sel <= 8'hE8 && sel >= 8'hD2 && sel != 8'hD4) begin
            k = (8'hE8 - sel) / 2;
            if (e[k]) return {1'b1, 8'hFF, sel};
        end
        for (int i = 0; i < 12; i++) begin
            if (e[i]) return {1'b1, 8'hFF, 8'(8'hE8 - 2 * i)};
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: apply at a falling edge, one rising edge later queue the expectation
    task automatic apply(input logic m, input logic [11:0] r, input logic [3:0] s,
                         input string tag);
        @(negedge clk);
        i_mask = m; req = r; sci_sub = s;
        @(negedge clk);
        exp_q.push_back(model(m, r, s, cur_sel));
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic m, input logic [7:0] d);
        @(negedge clk);
        i_mask = m; reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (m) cur_sel = {2'b11, d[5:1], 1'b0};
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), {irq_pending, irq_vector}, exp_q.pop_front());
            end
        end
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset rd", {9'h0, reg_rd_data}, {9'h0, 8'hF2});
        check("R1 reset out", {irq_pending, irq_vector}, 17'h0);

        // R3 each slot alone, R11 reserved slot ignored
        for (int i = 0; i < 12; i++) begin
            apply(1'b0, 12'(1) << i, 4'h0, (i == 10) ? "R11 reserved line" : "R3 single slot");
        end
        // R2 fixed order
        apply(1'b0, 12'b1001_0001_0000, 4'h0, "R2 mixed slots 4,8,11");
        apply(1'b0, 12'b1111_1111_1110, 4'h0, "R2 all but slot 0");
        apply(1'b0, 12'b1100_0000_0000, 4'h0, "R2 slots 10,11");
        // R12 latency: change and sample one edge later
        apply(1'b0, 12'h001, 4'h0, "R12 latency a");
        apply(1'b0, 12'h800, 4'h0, "R12 latency b");
        // R4 mask
        apply(1'b1, 12'hFFF, 4'hF, "R4 masked");
        // R5 locked write
        wr(1'b0, 8'hD8);
        check("R5 locked write", {9'h0, reg_rd_data}, {9'h0, 8'hF2});
        apply(1'b0, 12'h101, 4'h0, "R5 no elevation");
        // R6 fixed bits
        wr(1'b1, 8'h00);
        check("R6 zero write", {9'h0, reg_rd_data}, {9'h0, 8'hC0});
        wr(1'b1, 8'hFF);
        check("R6 ones write", {9'h0, reg_rd_data}, {9'h0, 8'hFE});
        // R7 elevation
        wr(1'b1, 8'hD8);
        check("R5 accepted write", {9'h0, reg_rd_data}, {9'h0, 8'hD8});
        apply(1'b0, 12'h101, 4'h0, "R7 SPI elevated");
        apply(1'b0, 12'hFFF, 4'h0, "R7 SPI elevated over all");
        // R8 elevation without request
        apply(1'b0, 12'h001, 4'h0, "R8 elevated idle");
        apply(1'b0, 12'h000, 4'h0, "R8 nothing pending");
        // R9 reserved and unmapped elevation values
        wr(1'b1, 8'hD4);
        apply(1'b0, 12'hE00, 4'h0, "R9 reserved elevate");
        wr(1'b1, 8'h80);
        apply(1'b0, 12'h880, 4'h0, "R9 unmapped elevate");
        wr(1'b1, 8'hD2);
        apply(1'b0, 12'h801, 4'h0, "R7 ATD elevated");
        // R10 SCI sub-conditions
        wr(1'b1, 8'hF2);
        for (int j = 0; j < 4; j++) begin
            apply(1'b0, 12'h800, 4'(1) << j, "R10 SCI sub-condition");
        end
        apply(1'b0, 12'h000, 4'h0, "R10 SCI idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule